// File: doc/BRIEF.md
# Delayed Chip Sequence Decoder

This block sits behind the chip slicer of a slope-modulated optical receiver. It turns hard-decided chips back into data bits. Each incoming chip is XORed with the chip before it to form a transition value. A short sliding window over the transition values then decides each bit.

A data 1 occupies NC-1 chips and carries exactly one transition. That transition sits at the end of the group when the line level is low, and at the start when the line level is high. A data 0 occupies one chip and carries no transition. The decoder tracks the line level and matches the window against the pattern for that level. On a match it emits 1 and drops the whole group. Otherwise it emits the window's first transition value and moves on by one position.

A packet holds PKT_BITS data bits. The transmitter follows each packet with NC-2 pad chips that hold the last line level. The decoder discards whatever part of that pad the last window did not need. It then starts the next packet with a clean history. A single chip error can corrupt every later bit of the same packet; the block does not try to detect or correct this.

Top module: `chip_seq_decoder`

## Requirements
- R1: The transition value of each chip is that chip XOR the previous accepted chip; the first chip of every packet, including the first after reset, is compared against 0.
- R2: With the line level low (after reset, at each packet start, and after an even number of decoded 1s), a window whose NC-1 values, oldest first, are all 0 except a 1 in the newest slot decodes as 1. It consumes all NC-1 values and sets the level high.
- R3: With the line level high, a window whose oldest value is 1 and whose other values are 0 decodes as 1. It consumes all NC-1 values and sets the level low.
- R4: Any other full window decodes as its oldest transition value and consumes one value; the level is unchanged.
- R5: A decision is taken only in the cycle when the chip that completes an NC-1 entry window is accepted. `bit_valid` rises in the following cycle, and never without an accepted chip in the cycle before.
- R6: `pkt_done` is high together with `bit_valid` on exactly the PKT_BITS-th bit of each packet and on no other bit.
- R7: After the last bit of a packet, the decoder drops the remaining pad chips. For NC-2 pad chips in total, it drops those the final window did not use. The next packet then decodes from a cleared history, with the previous chip 0, the level low and an empty window.
- R8: While `rst` is high and in the cycle after, `bit_valid` and `pkt_done` are 0.
- R9: With NC=3 and PKT_BITS=11, the chips 0,0,1,1,0,0,0,1,0,0,0,0,1,1,1,0,0 plus one pad chip 0 decode to 0,1,0,1,1,1,0,1,0,0,1. The bits appear after chips 2,3,5,6,8,10,12,13,15,16 and 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| chip_in | input | 1 | Hard-decided chip |
| chip_valid | input | 1 | `chip_in` holds a chip this cycle |
| bit_out | output | 1 | Decoded data bit |
| bit_valid | output | 1 | `bit_out` holds a bit this cycle |
| pkt_done | output | 1 | Marks the last bit of a packet |

## Verification
For NC = 3, 4 and 5, every 8-bit packet value is encoded in the bench and sent back to back, with pseudo-random idle gaps. This sweep covers runs of 1s that alternate between the low-level and high-level patterns. It also covers 0s placed just before either pattern, where a decoder that ignores the line level takes a 0 for a 1. It also shows whether pad chips leak into the next packet. The fixed NC=3 sequence pins down the exact cycle of every decision. Two packets made only of 1-chips follow it. The first transition of the second packet is 1 only if the previous chip was cleared to 0, and the later windows take the oldest-value path.

// File: rtl/chip_dec_pkg.sv
package chip_dec_pkg;
  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_DRAIN = 1'b1
  } dec_state_e;
endpackage

// File: rtl/cdec_edge.sv
module cdec_edge (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic chip_in,
  input  logic chip_vld,
  output logic trans_out,
  output logic trans_vld
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst || clr)    prev_q <= 1'b0;
    else if (chip_vld) prev_q <= chip_in;
  end

  assign trans_out = chip_in ^ prev_q;
  assign trans_vld = chip_vld;

  // history is cleared after a packet ends
  assert_prev_cleared_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (prev_q == 1'b0));
endmodule

// File: rtl/cdec_window.sv
module cdec_window #(
  parameter int NC = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic                          d_in,
  input  logic                          d_vld,
  output logic                          fire,
  output logic                          bit_dec,
  output logic [$clog2(NC)-1:0]         adv
);
  localparam int W  = NC - 1;
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam int AW = $clog2(NC);
  localparam logic [W-1:0] PAT_LO = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] PAT_HI = {{(W-1){1'b0}}, 1'b1};

  logic [W-2:0] buf_q;
  logic [CW-1:0] cnt_q;
  logic         lvl_q;
  logic [W-1:0] view;
  logic         full;
  logic         match;

  // view[0] is the oldest entry, view[W-1] the incoming one
  assign view  = {d_in, buf_q};
  assign full  = d_vld && (cnt_q == CW'(W-1));
  assign match = lvl_q ? (view == PAT_HI) : (view == PAT_LO);

  assign fire    = full;
  assign bit_dec = match ? 1'b1 : view[0];
  assign adv     = match ? AW'(W) : AW'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (full) begin
      cnt_q <= match ? '0 : CW'(W-1);
    end else if (d_vld) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < W-1; i++) begin
      if (full)                               buf_q[i] <= view[i+1];
      else if (d_vld && cnt_q == CW'(i))      buf_q[i] <= d_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)          lvl_q <= 1'b0;
    else if (full && match)  lvl_q <= ~lvl_q;
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(W-1));

  assert_level_flip_R3: assert property (@(posedge clk) disable iff (rst)
    (full && match && !clr) |=> (lvl_q != $past(lvl_q)));

  assert_level_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (full && !match && !clr) |=> $stable(lvl_q));
endmodule

// File: rtl/chip_seq_decoder.sv
module chip_seq_decoder #(
  parameter int NC       = 3,
  parameter int PKT_BITS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic chip_in,
  input  logic chip_valid,
  output logic bit_out,
  output logic bit_valid,
  output logic pkt_done
);
  import chip_dec_pkg::*;

  localparam int AW = $clog2(NC);
  localparam int BW = $clog2(PKT_BITS + 1);

  dec_state_e     state_q;
  logic [AW-1:0]  drop_q;
  logic [BW-1:0]  bidx_q;
  logic           run;
  logic           trans, trans_vld;
  logic           fire, bit_dec;
  logic [AW-1:0]  adv;
  logic           last;

  assign run  = (state_q == ST_RUN);
  assign last = fire && (bidx_q == BW'(PKT_BITS-1));

  cdec_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .clr       (last),
    .chip_in   (chip_in),
    .chip_vld  (chip_valid && run),
    .trans_out (trans),
    .trans_vld (trans_vld)
  );

  cdec_window #(.NC(NC)) u_win (
    .clk     (clk),
    .rst     (rst),
    .clr     (last),
    .d_in    (trans),
    .d_vld   (trans_vld),
    .fire    (fire),
    .bit_dec (bit_dec),
    .adv     (adv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
      pkt_done  <= 1'b0;
    end else begin
      bit_valid <= fire;
      pkt_done  <= last;
      if (fire) bit_out <= bit_dec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bidx_q  <= '0;
      state_q <= ST_RUN;
      drop_q  <= '0;
    end else begin
      if (fire) bidx_q <= last ? '0 : bidx_q + BW'(1);
      if (run) begin
        if (last && adv > AW'(1)) begin
          state_q <= ST_DRAIN;
          drop_q  <= adv - AW'(1);
        end
      end else if (chip_valid) begin
        drop_q <= drop_q - AW'(1);
        if (drop_q == AW'(1)) state_q <= ST_RUN;
      end
    end
  end

  assert_done_with_bit_R6: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> bit_valid);

  assert_bit_after_chip_R5: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> $past(chip_valid));

  assert_drain_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN) |=> !bit_valid);

  assert_index_bound_R6: assert property (@(posedge clk) disable iff (rst)
    bidx_q < BW'(PKT_BITS));
endmodule

// File: tb/chip_seq_decoder_tb.sv
module cdec_lane #(
  parameter int NC = 3,
  parameter int L  = 8
) (
  input  logic clk,
  input  logic rst,
  output int   checks,
  output int   errors,
  output logic fin
);
  logic chip_in, chip_valid, bit_out, bit_valid, pkt_done;
  logic drive_done;
  logic [15:0] lfsr;
  int pk, bi, dones;

  chip_seq_decoder #(.NC(NC), .PKT_BITS(L)) u_dut (
    .clk(clk), .rst(rst), .chip_in(chip_in), .chip_valid(chip_valid),
    .bit_out(bit_out), .bit_valid(bit_valid), .pkt_done(pkt_done)
  );

  task automatic push(input logic v);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (lfsr[0] && lfsr[3]) begin
      @(negedge clk);
      chip_valid = 1'b0;
    end
    @(negedge clk);
    chip_valid = 1'b1;
    chip_in    = v;
  endtask

  initial begin
    chip_in = 1'b0; chip_valid = 1'b0; drive_done = 1'b0;
    lfsr = 16'hACE1 + 16'(NC);
    @(negedge clk);
    while (rst) @(negedge clk);
    for (int p = 0; p < (1 << L); p++) begin
      logic lvl;
      lvl = 1'b0;
      for (int j = 0; j < L; j++) begin
        if (((p >> j) & 1) == 0) push(lvl);
        else if (!lvl) begin
          for (int z = 0; z < NC-2; z++) push(1'b0);
          push(1'b1);
          lvl = 1'b1;
        end else begin
          for (int z = 0; z < NC-1; z++) push(1'b0);
          lvl = 1'b0;
        end
      end
      for (int z = 0; z < NC-2; z++) push(lvl);
    end
    @(negedge clk);
    chip_valid = 1'b0;
    repeat (4) @(negedge clk);
    drive_done = 1'b1;
  end

  initial begin
    checks = 0; errors = 0; fin = 1'b0; pk = 0; bi = 0; dones = 0;
  end

  always @(negedge clk) begin
    if (!rst && !fin) begin
      if (bit_valid) begin
        logic eb, ed;
        eb = 1'((pk >> bi) & 1);
        ed = (bi == L-1);
        checks++;
        if (bit_out !== eb) begin
          errors++;
          $display("FAIL R2/R3/R4 NC=%0d pkt %0d bit %0d: got %b exp %b", NC, pk, bi, bit_out, eb);
        end
        checks++;
        if (pkt_done !== ed) begin
          errors++;
          $display("FAIL R6 NC=%0d pkt %0d bit %0d: done %b exp %b", NC, pk, bi, pkt_done, ed);
        end
        if (pkt_done) dones++;
        if (bi == L-1) begin bi = 0; pk++; end
        else bi++;
      end
      if (drive_done) begin
        checks++;
        if (pk != (1 << L) || bi != 0 || dones != (1 << L)) begin
          errors++;
          $display("FAIL R5/R7 NC=%0d totals: pkts %0d bits %0d dones %0d exp pkts %0d bits 0 dones %0d",
                   NC, pk, bi, dones, (1 << L), (1 << L));
        end
        fin = 1'b1;
      end
    end
  end
endmodule

module chip_seq_decoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_in = 1'b0, chip_valid = 1'b0;
  logic bit_out, bit_valid, pkt_done;
  int checks = 0, errors = 0;
  int c3, e3, c4, e4, c5, e5;
  logic f3, f4, f5;
  logic main_done = 1'b0;

  always #10 clk = ~clk;

  chip_seq_decoder #(.NC(3), .PKT_BITS(11)) u_dut (
    .clk(clk), .rst(rst), .chip_in(chip_in), .chip_valid(chip_valid),
    .bit_out(bit_out), .bit_valid(bit_valid), .pkt_done(pkt_done)
  );

  cdec_lane #(.NC(3), .L(8)) u_lane3 (.clk(clk), .rst(rst), .checks(c3), .errors(e3), .fin(f3));
  cdec_lane #(.NC(4), .L(8)) u_lane4 (.clk(clk), .rst(rst), .checks(c4), .errors(e4), .fin(f4));
  cdec_lane #(.NC(5), .L(8)) u_lane5 (.clk(clk), .rst(rst), .checks(c5), .errors(e5), .fin(f5));

  localparam logic [0:16] EX_CHIPS = 17'b00110001000011100;
  localparam logic [0:16] EX_FIRE  = 17'b01101101010110111;
  localparam logic [0:10] EX_BITS  = 11'b01011101001;

  task automatic step(input logic c, input logic ef, input logic eb, input logic ed, input string tag);
    chip_valid = 1'b1;
    chip_in    = c;
    @(negedge clk);
    chip_valid = 1'b0;
    checks++;
    if (bit_valid !== ef) begin
      errors++;
      $display("FAIL %s R5 bit_valid: got %b exp %b", tag, bit_valid, ef);
    end else if (ef) begin
      checks++;
      if (bit_out !== eb || pkt_done !== ed) begin
        errors++;
        $display("FAIL %s bit/done: got %b/%b exp %b/%b", tag, bit_out, pkt_done, eb, ed);
      end
    end
  endtask

  initial begin
    int bi;
    repeat (3) @(negedge clk);
    checks++;
    if (bit_valid !== 1'b0 || pkt_done !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset outputs: got %b/%b exp 0/0", bit_valid, pkt_done);
    end
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (bit_valid !== 1'b0 || pkt_done !== 1'b0) begin
      errors++;
      $display("FAIL R8 after reset: got %b/%b exp 0/0", bit_valid, pkt_done);
    end
    // R9 fixed sequence
    bi = 0;
    for (int i = 0; i < 17; i++) begin
      step(EX_CHIPS[i], EX_FIRE[i], EX_BITS[bi], bi == 10, "R9");
      if (EX_FIRE[i]) bi++;
    end
    // pad chip is dropped: R7
    step(1'b0, 1'b0, 1'b0, 1'b0, "R7 pad");
    // two all-ones packets: first transition 1 only if history cleared (R1), then R4 path
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 12; i++)
        step(1'b1, i > 0, i == 1, i == 11, p == 0 ? "R1/R4 pkt0" : "R1/R7 pkt1");
    end
    main_done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!(main_done && f3 && f4 && f5) && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: got timeout exp completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks + c3 + c4 + c5, errors + e3 + e4 + e5);
    $finish;
  end
endmodule